// File: doc/BRIEF.md
# Fractional Phase-Accumulator Baud Generator

This block produces a one-clock baud strobe from a slow kernel clock, such as a 32768 Hz crystal, and a programmable divisor. The strobe rate is 256 × f_clk / D. The block does not count down an integer divisor. A phase register gains 256 on every enabled clock. When the register reaches the divisor, the divisor is subtracted from it and a strobe is issued. Each strobe therefore falls on the nearest clock edge. When D is not a multiple of 256, the gap between strobes moves between the two integers on either side of D/256.

The divisor is loaded through a strobe and may change while the generator runs. A divisor below 768 is refused for timing: an invalid flag rises and no strobes come out. The strobe feeds a serial shifter downstream. It is a plain control pulse, so there is no handshake on any pin.

Top module: `frac_baud_gen`

## Requirements
- R1: After a synchronous reset, `tick` and `div_bad` are low, the divisor is 1024 and the phase register is zero. With `en` high and no load, the first `tick` is seen after the 4th enabled edge and then after every 4th edge.
- R2: Take a phase start value a0 (below D) and count n enabled edges with a valid divisor D. `tick` is high in the cycle after edge n exactly when floor((a0+256n)/D) > floor((a0+256(n-1))/D). It stays high for a single cycle.
- R3: After n enabled edges from a cleared phase, the number of strobes is floor(256n/D). For D = 874 and 2000 edges that is 585.
- R4: When D is a multiple of 256, strobes are exactly D/256 clocks apart. Otherwise the gap is floor(D/256) or ceil(D/256): 3 or 4 clocks for D = 874. Two strobes are always at least 3 clocks apart.
- R5: An edge with `en` low clears the phase register to zero, and `tick` is low in the following cycle.
- R6: `div_load` captures `div_in` at an edge. The comparison at that edge still uses the old divisor, and the new divisor applies from the next edge. The phase register is not cleared by a load.
- R7: If, on a load edge, the updated phase is at or above the new divisor, the phase register is set to zero.
- R8: A divisor below 768 (including 0) sets `div_bad` from the cycle after it is loaded. While it is held, no strobe appears and the phase register stays zero. A divisor of 768 is valid and gives a strobe every 3 clocks.
- R9: The divisor is 20 bits wide. The maximum value 1048575 works without overflow: the first strobe comes after edge 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low clears the phase |
| div_in | input | 20 | Divisor value to load |
| div_load | input | 1 | Load strobe for `div_in` |
| tick | output | 1 | One-cycle baud strobe |
| div_bad | output | 1 | Loaded divisor is below 768 |

## Verification
The bench aims at the load edge, because the comparison there must use the old divisor. A design that switched early would emit or drop a strobe at the load. The clamp is probed from both sides: a phase above the new divisor must give a full restart, and one below it must give an immediate strobe. A missing clamp shows up as an extra early strobe, and a clamp that is too eager shows up as a late one. The 767/768 boundary and the all-ones divisor are also covered. An off-by-one in the limit would let strobes through or block a legal rate, and an accumulator that is too narrow would wrap and never reach 4096 edges. Long runs at 874 and 1024 check the strobe count and the gaps against a floor-division model.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_BLOCKED = 2'd1,
    PH_RUN     = 2'd2
  } phase_mode_e;
endpackage

// File: rtl/fbg_div_reg.sv
module fbg_div_reg #(
  parameter int DIV_W     = 20,
  parameter int MIN_DIV   = 768,
  parameter int RESET_DIV = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  output logic [DIV_W-1:0] div_q,
  output logic             div_ok
);
  localparam logic [DIV_W-1:0] LOW_LIMIT = DIV_W'(MIN_DIV);
  localparam logic [DIV_W-1:0] INIT_DIV  = DIV_W'(RESET_DIV);

  always_ff @(posedge clk) begin
    if (rst)       div_q <= INIT_DIV;
    else if (load) div_q <= div_in;
  end

  assign div_ok = (div_q >= LOW_LIMIT);
endmodule

// File: rtl/fbg_mode_sel.sv
module fbg_mode_sel
  import fbg_pkg::*;
(
  input  logic        en,
  input  logic        div_ok,
  output phase_mode_e mode
);
  always_comb begin
    if (!en)          mode = PH_IDLE;
    else if (!div_ok) mode = PH_BLOCKED;
    else              mode = PH_RUN;
  end
endmodule

// File: rtl/fbg_phase_acc.sv
module fbg_phase_acc
  import fbg_pkg::*;
#(
  parameter int DIV_W = 20,
  parameter int STEP  = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  phase_mode_e      mode,
  input  logic [DIV_W-1:0] div_q,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick,
  output logic [DIV_W:0]   acc_q
);
  localparam int ACC_W = DIV_W + 1;
  localparam logic [ACC_W-1:0] INC = ACC_W'(STEP);

  logic [ACC_W-1:0] sum, upd, nxt;
  logic             hit;

  always_comb begin
    sum = acc_q + INC;
    hit = (mode == PH_RUN) && (sum >= {1'b0, div_q});
    if (mode != PH_RUN) upd = '0;
    else if (hit)       upd = sum - {1'b0, div_q};
    else                upd = sum;
    // a load may leave the phase at or beyond the new divisor: restart it
    nxt = (load && (upd >= {1'b0, div_in})) ? '0 : upd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else begin
      acc_q <= nxt;
      tick  <= hit;
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int DIV_W     = 20,
  parameter int STEP      = 256,
  parameter int MIN_DIV   = 768,
  parameter int RESET_DIV = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_in,
  input  logic             div_load,
  output logic             tick,
  output logic             div_bad
);
  logic [DIV_W-1:0] div_q;
  logic             div_ok;
  logic [DIV_W:0]   acc_q;
  phase_mode_e      mode;

  fbg_div_reg #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV), .RESET_DIV(RESET_DIV)) u_div (
    .clk(clk), .rst(rst), .load(div_load), .div_in(div_in),
    .div_q(div_q), .div_ok(div_ok)
  );

  fbg_mode_sel u_mode (.en(en), .div_ok(div_ok), .mode(mode));

  fbg_phase_acc #(.DIV_W(DIV_W), .STEP(STEP)) u_acc (
    .clk(clk), .rst(rst), .mode(mode), .div_q(div_q),
    .load(div_load), .div_in(div_in), .tick(tick), .acc_q(acc_q)
  );

  assign div_bad = ~div_ok;
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int DIV_W   = 20,
  parameter int MIN_DIV = 768
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [DIV_W-1:0] div_in,
  input logic             div_load,
  input logic             tick,
  input logic             div_bad,
  input logic [DIV_W-1:0] div_q,
  input logic [DIV_W:0]   acc_q
);
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tick);

  a_r8_bad_no_tick: assert property (@(posedge clk) disable iff (rst)
    div_bad |=> !tick);

  a_r8_flag_on_load: assert property (@(posedge clk) disable iff (rst)
    (div_load && (div_in < DIV_W'(MIN_DIV))) |=> div_bad);

  a_r7_phase_below_div: assert property (@(posedge clk) disable iff (rst)
    (div_q != '0) |-> (acc_q < {1'b0, div_q}));

  a_r4_min_gap: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick ##1 !tick);
endmodule

bind frac_baud_gen fbg_checker #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_chk (
  .clk(clk), .rst(rst), .en(en), .div_in(div_in), .div_load(div_load),
  .tick(tick), .div_bad(div_bad), .div_q(div_q), .acc_q(acc_q)
);

// File: tb/frac_baud_gen_test.sv
`timescale 1ns/1ps
module frac_baud_gen_test;
  logic        clk = 1'b0, rst = 1'b1, en = 1'b0, div_load = 1'b0;
  logic [19:0] div_in = '0;
  logic        tick, div_bad;

  always #2.5 clk = ~clk;

  frac_baud_gen uut (.clk(clk), .rst(rst), .en(en), .div_in(div_in),
                     .div_load(div_load), .tick(tick), .div_bad(div_bad));

  int     n_chk = 0, n_bad = 0;
  longint m_a0 = 0, m_n = 0, m_d = 1024;
  longint cyc = 0, last_tick = -1, tick_cnt = 0;
  bit     sp_on = 0, done = 0;
  longint sp_lo = 0, sp_hi = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; en = 1'b0; div_load = 1'b0;
    @(posedge clk); #1;
    m_a0 = 0; m_n = 0; m_d = 1024; last_tick = -1;
    chk("R1 tick after reset", tick, 0);
    chk("R1 div_bad after reset", div_bad, 0);
    rst = 1'b0;
  endtask

  task automatic step(input bit e, input bit ld, input logic [19:0] dv, input string tag);
    bit valid, exp_t;
    longint tot, a, iv;
    @(negedge clk); en = e; div_load = ld; div_in = dv;
    valid = (m_d >= 768);
    tot = 0;
    if (e && valid) begin
      m_n++;
      tot = m_a0 + 256 * m_n;
      exp_t = (tot / m_d) > ((tot - 256) / m_d);
    end else begin
      m_a0 = 0; m_n = 0; exp_t = 0;
    end
    if (ld) begin
      a = (e && valid) ? (tot % m_d) : 0;
      if (a >= longint'(dv)) a = 0;
      m_a0 = a; m_n = 0; m_d = longint'(dv);
    end
    @(posedge clk); #1; cyc++;
    chk(tag, tick, exp_t);
    chk("R8 div_bad", div_bad, (m_d < 768));
    if (tick) begin
      if (sp_on && last_tick >= 0) begin
        iv = cyc - last_tick;
        n_chk++;
        if (iv != sp_lo && iv != sp_hi) begin
          n_bad++;
          $display("FAIL R4 gap: got %0d expected %0d or %0d", iv, sp_lo, sp_hi);
        end
      end
      last_tick = cyc;
      tick_cnt++;
    end
  endtask

  function automatic logic [19:0] rand_div();
    int unsigned k = $urandom % 10;
    if (k == 0)      return 20'($urandom % 768);
    else if (k == 1) return 20'((($urandom % 20) + 3) * 256);
    else             return 20'(768 + ($urandom % 5000));
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    longint t0, c0;
    void'($urandom(32'd20240611));
    do_reset();
    // R1: default divisor 1024 -> every 4th edge
    for (int i = 0; i < 12; i++) step(1, 0, 20'd0, "R1 default rate");

    // R4: exact multiple, constant gap
    sp_on = 1; sp_lo = 4; sp_hi = 4; last_tick = -1;
    for (int i = 0; i < 40; i++) step(1, 0, 20'd0, "R2 D=1024");
    sp_on = 0;

    // R3 / R4: D=874 long run
    step(0, 1, 20'd874, "R5 idle load");
    tick_cnt = 0; last_tick = -1; sp_on = 1; sp_lo = 3; sp_hi = 4;
    for (int i = 0; i < 2000; i++) step(1, 0, 20'd0, "R2 D=874");
    sp_on = 0;
    chk("R3 strobe count D=874", tick_cnt, 585);

    // R5: enable low clears phase
    for (int i = 0; i < 3; i++) step(0, 0, 20'd0, "R5 enable low");
    t0 = tick_cnt;
    for (int i = 0; i < 3; i++) step(1, 0, 20'd0, "R5 restart");
    chk("R5 no strobe in 3 edges after clear", tick_cnt - t0, 0);
    step(1, 0, 20'd0, "R5 restart");
    chk("R5 strobe on 4th edge after clear", tick, 1);

    // R7: clamp when phase is above new divisor
    step(0, 1, 20'd4000, "R7 setup");
    for (int i = 0; i < 10; i++) step(1, 0, 20'd0, "R7 setup");
    step(1, 1, 20'd1000, "R7 load");
    t0 = tick_cnt;
    for (int i = 0; i < 3; i++) step(1, 0, 20'd0, "R7 after clamp");
    chk("R7 no early strobe after clamp", tick_cnt - t0, 0);
    step(1, 0, 20'd0, "R7 after clamp");
    chk("R7 strobe 4 edges after clamp", tick, 1);

    // R6: phase kept on load below new divisor
    step(0, 1, 20'd4000, "R6 setup");
    for (int i = 0; i < 10; i++) step(1, 0, 20'd0, "R6 setup");
    step(1, 1, 20'd3000, "R6 load");
    chk("R6 no strobe on load edge", tick, 0);
    step(1, 0, 20'd0, "R6 kept phase");
    chk("R6 immediate strobe from kept phase", tick, 1);

    // R6: load edge compares against old divisor
    step(0, 1, 20'd1024, "R6 setup");
    for (int i = 0; i < 3; i++) step(1, 0, 20'd0, "R6 setup");
    step(1, 1, 20'd2000, "R6 old divisor at load");
    chk("R6 strobe uses old divisor", tick, 1);

    // R8: 767 invalid, 768 valid
    step(1, 1, 20'd767, "R8 load 767");
    chk("R8 flag for 767", div_bad, 1);
    t0 = tick_cnt;
    for (int i = 0; i < 20; i++) step(1, 0, 20'd0, "R8 blocked");
    chk("R8 no strobes while invalid", tick_cnt - t0, 0);
    step(1, 1, 20'd768, "R8 load 768");
    chk("R8 flag clear for 768", div_bad, 0);
    sp_on = 1; sp_lo = 3; sp_hi = 3; last_tick = -1;
    for (int i = 0; i < 30; i++) step(1, 0, 20'd0, "R8 D=768");
    sp_on = 0;
    step(1, 1, 20'd0, "R8 load zero");
    chk("R8 flag for zero", div_bad, 1);

    // R9: largest divisor
    step(0, 1, 20'hFFFFF, "R9 load max");
    c0 = cyc; last_tick = -1;
    for (int i = 0; i < 4200; i++) step(1, 0, 20'd0, "R9 D=max");
    chk("R9 first strobe edge for max divisor", last_tick - c0, 4096);

    // random mix
    for (int s = 0; s < 60; s++) begin
      if (s % 15 == 7) do_reset();
      step(($urandom % 4) != 0, 1, rand_div(), "R2 random load");
      for (int i = 0; i < 120; i++) begin
        if (($urandom % 40) == 0) step(1, 1, rand_div(), "R6 random reload");
        else step(($urandom % 16) != 0, 0, 20'd0, "R2 random run");
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule